// File: doc/BRIEF.md
# HDB3/AMI Line Decoder with Code-Violation Checker

This block sits behind an external line receiver that splits a ternary HDB3 or AMI line into two unipolar rails: a positive-pulse rail and a negative-pulse rail. The rails arrive together with a receive clock that has been recovered outside the block. On every rising edge the block takes one line symbol. It removes valid HDB3 zero substitutions and emits the NRZ data stream a fixed four clocks later. For each symbol that breaks the active coding rule, it raises a one-clock error flag. It also drives a clock-recovery helper, which is the OR of the two rails and feeds the external clock extractor.

A mode pin selects HDB3 or AMI rules. The same pin also controls the paired encoder. A loop-test pin feeds the paired encoder's two output rails into the decoder in place of the line rails.

The symbol stream runs at a fixed rate of one symbol per clock. Each clock edge is an implicit "valid". The line cannot be paused, so the block has no ready or back-pressure signal: any downstream consumer must accept one NRZ bit every clock.

Top module: `hdb3_ami_rx`

## Requirements
- R1: After reset, `nrz_out` and `err_out` are 0, and the held line state is cleared. The first single-rail mark after reset is never a violation. For the window rule, symbols from before reset count as spaces.
- R2: With `loop_en`=1, the decoder uses `lb_pos`/`lb_neg` and ignores `rx_pos`/`rx_neg` entirely. With `loop_en`=0 it uses `rx_pos`/`rx_neg`.
- R3: `ckr_out` is, combinationally, the OR of the two selected rails.
- R4: A symbol sampled at rising edge k is shown on `nrz_out` from edge k+4 until edge k+5. Any mark decodes to 1 and a space (both rails low) decodes to 0, unless R8 applies.
- R5: `err_out` is high for exactly the one clock period after edge k when the symbol sampled at edge k is an offending symbol. A space never raises it.
- R6: When both rails are high, the symbol decodes as 1 and raises `err_out` in either mode. It does not change the remembered polarity of the last single-rail mark.
- R7: A violation is a single-rail mark on the same rail as the most recent single-rail mark. In AMI mode (`hdb3_en`=0), every violation raises `err_out` and decodes as 1.
- R8: In HDB3 mode, a violation at edge k is a valid substitution when the symbol at k-4 is a mark and the symbols at k-2 and k-1 are spaces. The symbols sampled at k-3, k-2, k-1 and k then all decode as 0.
- R9: In HDB3 mode, a violation that fails the R8 window raises `err_out`, decodes as 1 and clears no earlier symbol.
- R10: In HDB3 mode, a violation on the same rail as the previous violation raises `err_out`. Whether zeros are filled still follows R8.
- R11: `hdb3_en`=1 selects HDB3 rules and `hdb3_en`=0 selects AMI rules. The mode changes only how violations are handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock; rails sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_en | input | 1 | 1 = HDB3 rules, 0 = AMI rules |
| loop_en | input | 1 | 1 = decode the paired encoder's rails |
| rx_pos | input | 1 | Line positive-pulse rail |
| rx_neg | input | 1 | Line negative-pulse rail |
| lb_pos | input | 1 | Paired encoder positive output rail |
| lb_neg | input | 1 | Paired encoder negative output rail |
| nrz_out | output | 1 | Decoded NRZ data, four clocks behind the line |
| err_out | output | 1 | One-clock code-violation flag |
| ckr_out | output | 1 | OR of the selected rails, for clock extraction |

## Verification
The bench drives back-to-back substitutions of both forms, using both the zero-leading and the mark-leading pattern. A decoder that kept the substitution pulse as a one, or that cleared the wrong span of earlier symbols, would produce a stray one on `nrz_out`. It also drives violations whose window fails only at the oldest position. A decoder that checks only the two trailing spaces would then silently clear data instead of flagging an error.

A double-rail symbol is followed by a mark on the negative rail. If a decoder let the double-rail symbol update the polarity state, it would raise a false error on that mark. In loop-test mode the bench holds both line rails high, so any leak from the line rails shows up as errors.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  // Rail pair as sampled: bit 1 = negative rail, bit 0 = positive rail.
  typedef enum logic [1:0] {
    SYM_SPACE = 2'b00,
    SYM_POS   = 2'b01,
    SYM_NEG   = 2'b10,
    SYM_BOTH  = 2'b11
  } rail_sym_e;

  // Verdict on the symbol sampled this cycle.
  typedef struct packed {
    logic data;  // decoded value before any later zero fill
    logic fill;  // clear this symbol and the ones held behind it
    logic err;   // coding-rule breach
  } sym_verdict_t;

  function automatic logic sym_is_mark(input rail_sym_e s);
    return s != SYM_SPACE;
  endfunction

  function automatic logic sym_is_single(input rail_sym_e s);
    return (s == SYM_POS) || (s == SYM_NEG);
  endfunction

endpackage

// File: rtl/rx_rail_select.sv
module rx_rail_select
  import hdb3_rx_pkg::*;
(
  input  logic      loop_en,
  input  logic      rx_pos,
  input  logic      rx_neg,
  input  logic      lb_pos,
  input  logic      lb_neg,
  output rail_sym_e sym,
  output logic      ckr
);

  logic [1:0] rails;

  always_comb begin
    if (loop_en) rails = {lb_neg, lb_pos};
    else         rails = {rx_neg, rx_pos};
  end

  assign sym = rail_sym_e'(rails);
  assign ckr = |rails;

endmodule

// File: rtl/rx_violation_check.sv
module rx_violation_check
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned WIN = 4   // substitution length in symbols
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hdb3_en,
  input  rail_sym_e    sym,
  output sym_verdict_t verdict,
  output logic         err_q
);

  // hist[0] holds the mark flag of the symbol one edge back,
  // hist[WIN-1] the one WIN edges back.
  localparam int unsigned OLDEST = WIN - 1;

  logic [WIN-1:0] hist;
  logic           last_neg;
  logic           mark_seen;
  logic           lastv_neg;
  logic           viol_seen;

  logic is_mark, is_single, is_neg, is_both;
  logic viol, window_ok, repeat_v;

  always_comb begin
    is_mark   = sym_is_mark(sym);
    is_single = sym_is_single(sym);
    is_neg    = (sym == SYM_NEG);
    is_both   = (sym == SYM_BOTH);

    viol      = is_single && mark_seen && (is_neg == last_neg);
    window_ok = hist[OLDEST] && !hist[1] && !hist[0];
    repeat_v  = viol && viol_seen && (is_neg == lastv_neg);

    verdict.fill = 1'b0;
    verdict.data = is_mark;
    verdict.err  = is_both;

    if (hdb3_en) begin
      if (viol && window_ok) begin
        verdict.fill = 1'b1;
        verdict.data = 1'b0;
      end
      if ((viol && !window_ok) || repeat_v) verdict.err = 1'b1;
    end else begin
      if (viol) verdict.err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      last_neg  <= 1'b0;
      mark_seen <= 1'b0;
      lastv_neg <= 1'b0;
      viol_seen <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      hist  <= {hist[WIN-2:0], is_mark};
      err_q <= verdict.err;
      if (is_single) begin
        last_neg  <= is_neg;
        mark_seen <= 1'b1;
      end
      if (viol) begin
        lastv_neg <= is_neg;
        viol_seen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_fill_pipe.sv
module rx_fill_pipe #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic fill,
  output logic nrz_q
);

  // sr[0] newest; a fill clears every stage, which after the shift
  // holds exactly the current symbol and the WIN-1 before it.
  logic [WIN-1:0] sr;
  logic [WIN-1:0] nxt;

  for (genvar i = 0; i < WIN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = bit_in;
    end else begin : g_body
      assign nxt[i] = sr[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      nrz_q <= 1'b0;
    end else begin
      nrz_q <= sr[WIN-1];
      sr    <= fill ? '0 : nxt;
    end
  end

endmodule

// File: rtl/hdb3_ami_rx.sv
module hdb3_ami_rx
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned SUB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_en,
  input  logic loop_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic lb_pos,
  input  logic lb_neg,
  output logic nrz_out,
  output logic err_out,
  output logic ckr_out
);

  rail_sym_e    sym;
  sym_verdict_t verdict;

  rx_rail_select u_sel (
    .loop_en (loop_en),
    .rx_pos  (rx_pos),
    .rx_neg  (rx_neg),
    .lb_pos  (lb_pos),
    .lb_neg  (lb_neg),
    .sym     (sym),
    .ckr     (ckr_out)
  );

  rx_violation_check #(.WIN(SUB_LEN)) u_chk_rules (
    .clk     (clk),
    .rst_n   (rst_n),
    .hdb3_en (hdb3_en),
    .sym     (sym),
    .verdict (verdict),
    .err_q   (err_out)
  );

  rx_fill_pipe #(.WIN(SUB_LEN)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (verdict.data),
    .fill   (verdict.fill),
    .nrz_q  (nrz_out)
  );

endmodule

// File: rtl/hdb3_ami_rx_chk.sv
module hdb3_ami_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic hdb3_en,
  input logic loop_en,
  input logic rx_pos,
  input logic rx_neg,
  input logic lb_pos,
  input logic lb_neg,
  input logic nrz_out,
  input logic err_out,
  input logic ckr_out
);

  logic       sel_p, sel_n, sel_mark;
  logic [2:0] ami_run;

  assign sel_p    = loop_en ? lb_pos : rx_pos;
  assign sel_n    = loop_en ? lb_neg : rx_neg;
  assign sel_mark = sel_p | sel_n;

  // Consecutive AMI-mode edges, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ami_run <= '0;
    else if (hdb3_en)        ami_run <= '0;
    else if (ami_run != 3'd7) ami_run <= ami_run + 3'd1;
  end

  // R3 / R2: in loop test the helper follows the encoder rails.
  a_r3_ckr_loop: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (ckr_out == (lb_pos | lb_neg)));

  // R6: a double-rail symbol is flagged in the next cycle.
  a_r6_both_err: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_p && sel_n) |=> err_out);

  // R5: a space never raises the flag.
  a_r5_space_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_p && !sel_n) |=> !err_out);

  // R4: with AMI rules held long enough, data is the mark delayed by four.
  a_r4_ami_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (ami_run >= 3'd6) |-> (nrz_out == $past(sel_mark, 5)));

endmodule

bind hdb3_ami_rx hdb3_ami_rx_chk u_rx_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hdb3_en (hdb3_en),
  .loop_en (loop_en),
  .rx_pos  (rx_pos),
  .rx_neg  (rx_neg),
  .lb_pos  (lb_pos),
  .lb_neg  (lb_neg),
  .nrz_out (nrz_out),
  .err_out (err_out),
  .ckr_out (ckr_out)
);

// File: tb/hdb3_ami_rx_tb.sv
`timescale 1ns/1ps
module hdb3_ami_rx_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdb3_en = 1'b1, loop_en = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
  logic nrz_out, err_out, ckr_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_on   = 1'b0;
  bit done     = 1'b0;

  bit    exp_nrz_q[$];
  bit    exp_err_q[$];
  string tag_q[$];

  // Encoder model state (built from the line code, not from the decoder).
  bit enc_last_neg;
  bit enc_odd;
  bit bits[0:255];
  bit sp[0:255];
  bit sn[0:255];

  always #2 clk = ~clk;

  hdb3_ami_rx u_dut (
    .clk(clk), .rst_n(rst_n), .hdb3_en(hdb3_en), .loop_en(loop_en),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .lb_pos(lb_pos), .lb_neg(lb_neg),
    .nrz_out(nrz_out), .err_out(err_out), .ckr_out(ckr_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compares outputs against the scoreboard after each edge.
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (exp_err_q.size() > 0) begin
        bit e;
        e = exp_err_q.pop_front();
        check(err_out == e, "R5 err flag", err_out, e);
      end
      if (exp_nrz_q.size() > 4) begin
        bit d;
        string t;
        d = exp_nrz_q.pop_front();
        t = tag_q.pop_front();
        check(nrz_out == d, t, nrz_out, d);
      end
    end
  end

  // Driver: one symbol per clock; rails go to the selected source.
  task automatic drive_sym(input bit p, input bit n, input bit ed, input bit ee,
                           input string t);
    @(negedge clk);
    if (loop_en) begin
      lb_pos = p; lb_neg = n; rx_pos = 1'b1; rx_neg = 1'b1;
    end else begin
      rx_pos = p; rx_neg = n; lb_pos = 1'b0; lb_neg = 1'b0;
    end
    exp_nrz_q.push_back(ed);
    exp_err_q.push_back(ee);
    tag_q.push_back(t);
    #0.5;
    check(ckr_out == (p | n), "R3 ckr helper", ckr_out, p | n);
  endtask

  task automatic flush();
    for (int i = 0; i < 6; i++) drive_sym(1'b0, 1'b0, 1'b0, 1'b0, "R4 flush");
  endtask

  // Symbols: P = positive rail, N = negative rail, 0 = space, D = both rails.
  task automatic run_pattern(input string s, input string d, input string e,
                             input string t);
    for (int i = 0; i < s.len(); i++) begin
      bit p, n;
      p = (s[i] == "P") || (s[i] == "D");
      n = (s[i] == "N") || (s[i] == "D");
      drive_sym(p, n, d[i] == "1", e[i] == "1", t);
    end
    flush();
  endtask

  task automatic do_reset(input bit mode, input bit loop);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n  = 1'b0;
    rx_pos = 0; rx_neg = 0; lb_pos = 0; lb_neg = 0;
    hdb3_en = mode; loop_en = loop;
    exp_nrz_q.delete(); exp_err_q.delete(); tag_q.delete();
    enc_last_neg = 1'b1;
    enc_odd      = 1'b0;
    repeat (3) @(negedge clk);
    check(nrz_out == 1'b0, "R1 reset nrz", nrz_out, 0);
    check(err_out == 1'b0, "R1 reset err", err_out, 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
  endtask

  // HDB3 encoding of bits[0:len-1] into sp/sn.
  task automatic encode_hdb3(input int len);
    int i = 0;
    while (i < len) begin
      bit run4;
      run4 = (i + 3 < len) && !bits[i] && !bits[i+1] && !bits[i+2] && !bits[i+3];
      if (bits[i]) begin
        enc_last_neg = !enc_last_neg;
        sp[i] = !enc_last_neg; sn[i] = enc_last_neg;
        enc_odd = !enc_odd;
        i++;
      end else if (run4) begin
        for (int j = 0; j < 4; j++) begin sp[i+j] = 0; sn[i+j] = 0; end
        if (!enc_odd) begin
          enc_last_neg = !enc_last_neg;
          sp[i] = !enc_last_neg; sn[i] = enc_last_neg;
        end
        sp[i+3] = !enc_last_neg; sn[i+3] = enc_last_neg;
        enc_odd = 1'b0;
        i += 4;
      end else begin
        sp[i] = 0; sn[i] = 0;
        i++;
      end
    end
  endtask

  task automatic encode_ami(input int len);
    for (int i = 0; i < len; i++) begin
      sp[i] = 0; sn[i] = 0;
      if (bits[i]) begin
        enc_last_neg = !enc_last_neg;
        sp[i] = !enc_last_neg; sn[i] = enc_last_neg;
      end
    end
  endtask

  task automatic fill_random(input int len, input int zero_bias);
    for (int i = 0; i < len; i++) bits[i] = (($urandom % 100) >= zero_bias);
    bits[0] = 1'b1;
  endtask

  task automatic send_stream(input int len, input string t);
    for (int i = 0; i < len; i++) drive_sym(sp[i], sn[i], bits[i], 1'b0, t);
    flush();
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed));

    // R7 / R1 / R11: AMI rules; the first mark (negative) is not a violation.
    do_reset(1'b0, 1'b0);
    run_pattern("NPNN00", "111100", "000100", "R7 ami violation");

    // R6: double rail decodes as one and leaves polarity untouched.
    do_reset(1'b1, 1'b0);
    run_pattern("PDNP", "1111", "0100", "R6 double rail");

    // R8 / R10: 000V then B00V, then a repeated-rail violation.
    do_reset(1'b1, 1'b0);
    run_pattern("P000PN00NPN000N", "100000000110000", "000000000000001",
                "R8 R10 substitution");

    // R9: window fails on trailing mark.
    do_reset(1'b1, 1'b0);
    run_pattern("PN0N", "1101", "0001", "R9 window trailing");

    // R9: window fails only at the oldest position.
    do_reset(1'b1, 1'b0);
    run_pattern("0P00P", "01001", "00001", "R9 window oldest");

    // R8 / R4: random HDB3 traffic with frequent zero runs.
    do_reset(1'b1, 1'b0);
    fill_random(200, 65);
    encode_hdb3(200);
    send_stream(200, "R8 hdb3 stream");

    // R4 / R11: random AMI traffic.
    do_reset(1'b0, 1'b0);
    fill_random(120, 50);
    encode_ami(120);
    send_stream(120, "R4 ami stream");

    // R2: loop test with the line rails held in the double-rail state.
    do_reset(1'b1, 1'b1);
    fill_random(80, 60);
    encode_hdb3(80);
    send_stream(80, "R2 loop test");

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule